// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Count Shifter

This block is the integer execute stage of a 64-bit register-file coprocessor. Each cycle it can accept one operation together with its operands: two source values and the old content of the destination register. One clock later it returns the new destination value. The surrounding pipeline owns the register file. It reads the old destination for every operation and writes back whatever this unit returns. The unit therefore decides which half of a register changes.

A 2-bit group field and a 3-bit sub-opcode are decoded from the instruction word. Together they select one of these operations:

- 32-bit and 64-bit shifts;
- 32-bit and 64-bit multiplies;
- 32-bit multiply-accumulate and multiply-subtract into the old destination;
- absolute value, negation, addition and subtraction, each at both widths.

A shift count is signed, and its sign gives the direction. The count comes from one of two places. It can be a 7-bit immediate split across two instruction fields. It can also be a 32-bit value taken from a host register when the shift-by-register form is selected. Codes that this unit does not execute raise an illegal flag and return the destination unchanged.

Top module: `int_exec_shift`

## Requirements
- R1: The group is instruction bits 21:20 and the sub-opcode is bits 7:5. The encodings are:
  - group 0: 32-bit shift.
  - group 1: sub-opcode 0 is mul32, 1 is mul64, 2 is mac32, 3 is msc32; sub-opcodes 4 to 7 are not executed here.
  - group 2: 64-bit shift.
  - group 3: sub-opcodes 0 to 7 are, in order, abs32, abs64, neg32, neg64, add32, add64, sub32, sub64.
- R2: The immediate shift count is 7 bits, signed two's complement, formed as {bits 7:5, bits 3:0}. A count of zero or more shifts left by that count. A negative count shifts right arithmetically by its magnitude.
- R3: When host_sel is 1, the shift groups take their count from host_cnt, a signed 32-bit value, with the same sign convention as R2. For groups 1 and 3, host_sel has no effect.
- R4: A shift whose magnitude is at least the operand width (32 or 64) returns zero when shifting left. When shifting right it returns copies of the operand's sign bit.
- R5: Every 32-bit operation computes on bits 31:0 of its operands and writes only bits 31:0 of the result. Bits 63:32 of the result equal bits 63:32 of dest_old.
- R6: mul32 and mul64 return the product truncated to the operand width.
- R7: mac32 returns dest_old[31:0] + a*b, and msc32 returns dest_old[31:0] - a*b. Both wrap at 32 bits.
- R8: Addition, subtraction and negation wrap at the operand width. Absolute value of the most negative number returns that same number.
- R9: A group-1 sub-opcode from 4 to 7 sets illegal to 1 and returns dest_old unchanged. Every other code returns illegal as 0.
- R10: Timing and reset:
  - out_valid is in_valid delayed by one clock.
  - result and illegal belong to the operation accepted in the previous cycle.
  - illegal is 0 whenever out_valid is 0.
  - result holds its last value while no operation is accepted.
  - Reset clears out_valid, illegal and result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word: group, sub-opcode and shift immediate |
| opnd_a | input | 64 | First source register |
| opnd_b | input | 64 | Second source register |
| dest_old | input | 64 | Current destination register content |
| host_sel | input | 1 | Take the shift count from host_cnt |
| host_cnt | input | 32 | Signed shift count from a host register |
| out_valid | output | 1 | result is valid |
| result | output | 64 | New destination value |
| illegal | output | 1 | Accepted operation was not executable |

## Verification
Two functions can land in the same cycle: selecting the shift-count source, and detecting an illegal code. The bench provokes this by raising host_sel with a shift-group code. It does the same with a non-shift code and with an unexecuted group-1 code. A result is correct only if the host count is applied to shifts alone, and the illegal path still returns dest_old with the flag raised. Operations are streamed back to back, so every pipelined result is judged in the cycle after the operation is accepted. Idle cycles placed between operations confirm that the output holds its last value.

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
  parameter int W = 64,
  parameter int H = W / 2,
  parameter int CW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] dest_old,
  input  logic         host_sel,
  input  logic [CW-1:0] host_cnt,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         illegal
);

  localparam int LH = $clog2(H);
  localparam int LW = $clog2(W);

  logic [1:0] grp;
  logic [2:0] sub;
  logic [6:0] imm;
  logic [CW-1:0] cnt, mag;
  logic right;

  assign grp   = instr[21:20];
  assign sub   = instr[7:5];
  assign imm   = {instr[7:5], instr[3:0]};
  assign cnt   = host_sel ? host_cnt : {{(CW-7){imm[6]}}, imm};
  assign right = cnt[CW-1];
  assign mag   = right ? (~cnt + 1'b1) : cnt;

  logic [H-1:0] a32, b32, d32;
  assign a32 = opnd_a[H-1:0];
  assign b32 = opnd_b[H-1:0];
  assign d32 = dest_old[H-1:0];

  logic [H-1:0] sh32;
  logic [W-1:0] sh64;
  always_comb begin
    if (mag >= CW'(H))
      sh32 = right ? {H{a32[H-1]}} : '0;
    else if (right)
      sh32 = H'($signed(a32) >>> mag[LH-1:0]);
    else
      sh32 = a32 << mag[LH-1:0];
    if (mag >= CW'(W))
      sh64 = right ? {W{opnd_a[W-1]}} : '0;
    else if (right)
      sh64 = W'($signed(opnd_a) >>> mag[LW-1:0]);
    else
      sh64 = opnd_a << mag[LW-1:0];
  end

  logic [H-1:0] p32;
  logic [W-1:0] p64;
  assign p32 = a32 * b32;
  assign p64 = opnd_a * opnd_b;

  logic [W-1:0] nxt;
  logic         bad;
  always_comb begin
    bad = 1'b0;
    nxt = dest_old;
    unique case (grp)
      2'd0: nxt = {dest_old[W-1:H], sh32};
      2'd2: nxt = sh64;
      2'd1:
        case (sub)
          3'd0: nxt = {dest_old[W-1:H], p32};
          3'd1: nxt = p64;
          3'd2: nxt = {dest_old[W-1:H], d32 + p32};
          3'd3: nxt = {dest_old[W-1:H], d32 - p32};
          default: bad = 1'b1;
        endcase
      default:
        case (sub)
          3'd0: nxt = {dest_old[W-1:H], a32[H-1] ? -a32 : a32};
          3'd1: nxt = opnd_a[W-1] ? -opnd_a : opnd_a;
          3'd2: nxt = {dest_old[W-1:H], -a32};
          3'd3: nxt = -opnd_a;
          3'd4: nxt = {dest_old[W-1:H], a32 + b32};
          3'd5: nxt = opnd_a + opnd_b;
          3'd6: nxt = {dest_old[W-1:H], a32 - b32};
          default: nxt = opnd_a - opnd_b;
        endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & bad;
      if (in_valid) result <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !illegal); // R10
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> result == $past(dest_old)); // R9
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[21:20] == 2'd0) |=> result[W-1:H] == $past(dest_old[W-1:H])); // R5
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[21:20] == 2'd2 && !host_sel && instr[7:5] == 3'd0 && instr[3:0] == 4'd0)
      |=> result == $past(opnd_a)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R10

endmodule

// File: tb/sim_int_exec_shift.sv
module sim_int_exec_shift;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0, dest_old = '0;
  logic host_sel = 1'b0;
  logic [31:0] host_cnt = '0;
  logic out_valid, illegal;
  logic [63:0] result;

  int_exec_shift u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dest_old(dest_old), .host_sel(host_sel),
    .host_cnt(host_cnt), .out_valid(out_valid), .result(result), .illegal(illegal));

  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0]  rq;
    logic [31:0] ins;
    logic [63:0] a, b, d;
    logic [31:0] hc;
    logic        hs;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 27;
  localparam logic [63:0] DK = 64'hDEAD_BEEF_0000_0000;
  localparam logic [329:0] TV [0:NV-1] = '{
    // R2 R5: shift32 +4
    {8'd2, 32'h0000_0004, 64'hAAAA_AAAA_0000_00F1, 64'h0, 64'h1111_2222_3333_4444, 32'h0, 1'b0, 64'h1111_2222_0000_0F10, 1'b0},
    // R2: shift32 -4 arithmetic
    {8'd2, 32'h0000_00EC, 64'h0000_0000_8000_0010, 64'h0, 64'h1111_2222_3333_4444, 32'h0, 1'b0, 64'h1111_2222_F800_0001, 1'b0},
    // R2: shift64 +63
    {8'd2, 32'h0020_006F, 64'h1, 64'h0, DK, 32'h0, 1'b0, 64'h8000_0000_0000_0000, 1'b0},
    // R4: shift64 -64 sign fill
    {8'd4, 32'h0020_0080, 64'h8000_0000_0000_0000, 64'h0, DK, 32'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    // R2: shift64 -1
    {8'd2, 32'h0020_00EF, 64'h100, 64'h0, DK, 32'h0, 1'b0, 64'h80, 1'b0},
    // R2: shift64 by zero
    {8'd2, 32'h0020_0000, 64'h1234_5678_9ABC_DEF0, 64'h0, DK, 32'h0, 1'b0, 64'h1234_5678_9ABC_DEF0, 1'b0},
    // R3: host count -8 on shift32
    {8'd3, 32'h0000_0005, 64'h0000_0000_7000_0000, 64'h0, DK, 32'hFFFF_FFF8, 1'b1, 64'hDEAD_BEEF_0070_0000, 1'b0},
    // R4: host count 100 left on shift64
    {8'd4, 32'h0020_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, DK, 32'd100, 1'b1, 64'h0, 1'b0},
    // R4: host count -100 right, positive operand
    {8'd4, 32'h0020_0000, 64'h4000_0000_0000_0000, 64'h0, DK, 32'hFFFF_FF9C, 1'b1, 64'h0, 1'b0},
    // R4: shift32 by +32 from host
    {8'd4, 32'h0000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0, DK, 32'd32, 1'b1, 64'hDEAD_BEEF_0000_0000, 1'b0},
    // R6: mul32 truncated
    {8'd6, 32'h0010_0000, 64'h0001_0000, 64'h0001_0003, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_0003_0000, 1'b0},
    // R6: mul64 truncated
    {8'd6, 32'h0010_0020, 64'h1_0000_0000, 64'h1_0000_0002, DK, 32'h0, 1'b0, 64'h0000_0002_0000_0000, 1'b0},
    // R7: mac32
    {8'd7, 32'h0010_0040, 64'h3, 64'h5, 64'h5555_5555_0000_0010, 32'h0, 1'b0, 64'h5555_5555_0000_001F, 1'b0},
    // R7: msc32 wraps
    {8'd7, 32'h0010_0060, 64'h3, 64'h5, 64'h0000_0009_0000_0005, 32'h0, 1'b0, 64'h0000_0009_FFFF_FFF6, 1'b0},
    // R9: group1 sub4
    {8'd9, 32'h0010_0080, 64'h3, 64'h5, 64'h0123_4567_89AB_CDEF, 32'h0, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b1},
    // R9: group1 sub7 with host_sel raised
    {8'd9, 32'h0010_00E0, 64'h3, 64'h5, 64'hFEDC_BA98_7654_3210, 32'd3, 1'b1, 64'hFEDC_BA98_7654_3210, 1'b1},
    // R8: abs32
    {8'd8, 32'h0030_0000, 64'hFFFF_FFFB, 64'h0, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_0000_0005, 1'b0},
    // R8: abs64 of min
    {8'd8, 32'h0030_0020, 64'h8000_0000_0000_0000, 64'h0, DK, 32'h0, 1'b0, 64'h8000_0000_0000_0000, 1'b0},
    // R8: neg32
    {8'd8, 32'h0030_0040, 64'h1, 64'h0, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 1'b0},
    // R8: neg64
    {8'd8, 32'h0030_0060, 64'h5, 64'h0, DK, 32'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0},
    // R5 R8: add32 no carry into upper
    {8'd5, 32'h0030_0080, 64'hFFFF_FFFF, 64'h2, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_0000_0001, 1'b0},
    // R8: add64 carries
    {8'd8, 32'h0030_00A0, 64'hFFFF_FFFF, 64'h1, DK, 32'h0, 1'b0, 64'h1_0000_0000, 1'b0},
    // R8: sub32
    {8'd8, 32'h0030_00C0, 64'h0, 64'h1, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 1'b0},
    // R8: sub64
    {8'd8, 32'h0030_00E0, 64'h0, 64'h1, DK, 32'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    // R3: host_sel ignored by add64
    {8'd3, 32'h0030_00A0, 64'h10, 64'h20, DK, 32'd5, 1'b1, 64'h30, 1'b0},
    // R1: group 3 sub 0 vs group 1 sub 0 decode
    {8'd1, 32'h0030_0000, 64'h0000_0000_0000_0007, 64'h9, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_0000_0007, 1'b0},
    // R1: group1 sub0 on same data multiplies
    {8'd1, 32'h0010_0000, 64'h0000_0000_0000_0007, 64'h9, DK, 32'h0, 1'b0, 64'hDEAD_BEEF_0000_003F, 1'b0}
  };

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {63'b0, out_valid}, 64'd0);
    chk("R10 reset result", result, 64'd0);
    chk("R10 reset illegal", {63'b0, illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      v = TV[i];
      in_valid = 1'b1; instr = v.ins; opnd_a = v.a; opnd_b = v.b;
      dest_old = v.d; host_cnt = v.hc; host_sel = v.hs;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", v.rq, i), result, v.exp);
      chk($sformatf("R%0d vec%0d illegal", v.rq, i), {63'b0, illegal}, {63'b0, v.ill});
      chk("R10 valid", {63'b0, out_valid}, 64'd1);
    end
    // R10 R9: idle with an illegal code on the bus
    in_valid = 1'b0; instr = 32'h0010_0080; dest_old = 64'h77;
    @(negedge clk);
    chk("R10 idle valid", {63'b0, out_valid}, 64'd0);
    chk("R10 idle illegal", {63'b0, illegal}, 64'd0);
    chk("R10 idle hold", result, TV[NV-1][64:1]);
    // R7: two accumulations back to back, second uses fed-back value
    in_valid = 1'b1; instr = 32'h0010_0040; opnd_a = 64'd2; opnd_b = 64'd3;
    dest_old = 64'h0000_0001_0000_0004; host_sel = 1'b0;
    @(negedge clk);
    chk("R7 mac first", result, 64'h0000_0001_0000_000A);
    dest_old = result;
    @(negedge clk);
    chk("R7 mac second", result, 64'h0000_0001_0000_0010);
    in_valid = 1'b0;
    // R10: reset mid-stream clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset result", result, 64'd0);
    chk("R10 async reset valid", {63'b0, out_valid}, 64'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule